// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Execution Unit

This unit carries out one arithmetic/logic instruction against a private bank of four 16-bit accumulators and a single carry flag. A caller presents a 16-bit instruction word together with a one-cycle start strobe. In the same cycle, the unit does five things in a fixed order:

1. It conditions the carry.
2. It applies one of eight word functions to a source and a destination accumulator.
3. It optionally rotates the 17-bit carry-and-result value or swaps the result's bytes.
4. It writes the result and carry back, unless writeback is suppressed.
5. It evaluates one of eight skip tests on the final value.

The registered accumulators, the carry and the skip decision are visible on output ports. A sequencer outside the unit consumes the skip flag to decide whether the following instruction is bypassed.

Top module: `alc_exec_unit`

## Requirements
- R1: After synchronous reset, all four accumulators read zero, the carry reads 0, and skip and done are both low.
- R2: A strobed word whose most significant bit (instr_i[15]) is 0 is not an instruction of this class. It changes no accumulator and not the carry, and done stays low.
- R3: Field positions, with instr_i[15] as the class bit: source index instr_i[14:13], destination index instr_i[12:11], function instr_i[10:8], shift instr_i[7:6], carry control instr_i[5:4], writeback-suppress instr_i[3], skip test instr_i[2:0].
- R4: Carry control sets the base carry before the function runs: 0 keeps the current carry, 1 forces 0, 2 forces 1, 3 inverts it.
- R5: Function codes are 0 = ones' complement of source, 1 = two's negate of source, 2 = copy source, 3 = source plus one, 4 = destination plus complemented source, 5 = destination minus source, 6 = source plus destination, 7 = bitwise AND. An unsigned carry out of bit 15 from codes 1 and 3 to 6 inverts the base carry. Codes 0, 2 and 7 never produce one.
- R6: Shift codes: 0 leaves the value unchanged. 1 rotates the 17-bit {carry, result} left by one, so the carry takes result bit 15. 2 rotates it right by one, so the carry takes result bit 0. 3 exchanges the result's two bytes and leaves the carry untouched.
- R7: When writeback-suppress is 1, neither the destination accumulator nor the carry changes. The skip test still judges the shifted result and carry.
- R8: Skip codes: 0 never, 1 always, 2 carry is 0, 3 carry is 1, 4 result is zero, 5 result is nonzero, 6 carry is 0 or result is zero, 7 carry is 1 and result is nonzero. A passing test sets skip_o to 1.
- R9: Source and destination may name the same accumulator, and the operation then reads both operands from that one register.
- R10: The accumulators, carry and skip_o take their new values at the clock edge that samples an accepted strobe. done_o is high for exactly the one cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Strobe: execute instr_i this cycle |
| instr_i | input | 16 | Instruction word |
| done_o | output | 1 | One-cycle pulse after an accepted instruction |
| skip_o | output | 1 | Registered skip decision of the last accepted instruction |
| carry_o | output | 1 | Carry flag |
| acc_o | output | 64 | Accumulator bank, accumulator k at bits [16k+15:16k] |

## Verification
Every result has one register of latency. The accumulators, carry_o and skip_o all change at the rising edge that samples start_i. done_o rises at that same edge and falls at the next one. The bench drives each strobe at a falling edge and compares at the following falling edge, half a period after the update, so it never samples at the edge itself. In one directed case it waits one more cycle to confirm that done_o has dropped and nothing else has moved. Operands are planted through the unit's own copy-and-rotate instructions, so every accumulator write is checked against the same arithmetic model as the sweep.

// File: rtl/alc_pkg.sv
package alc_pkg;

    localparam int WORD_W   = 16;
    localparam int BYTE_W   = WORD_W / 2;
    localparam int NUM_AC   = 4;
    localparam int AC_IDX_W = $clog2(NUM_AC);

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        FN_COM = 3'd0,
        FN_NEG = 3'd1,
        FN_MOV = 3'd2,
        FN_INC = 3'd3,
        FN_ADC = 3'd4,
        FN_SUB = 3'd5,
        FN_ADD = 3'd6,
        FN_AND = 3'd7
    } func_e;

    typedef enum logic [1:0] {
        SH_NONE = 2'd0,
        SH_ROL  = 2'd1,
        SH_ROR  = 2'd2,
        SH_SWAP = 2'd3
    } shift_e;

    typedef enum logic [1:0] {
        CY_KEEP = 2'd0,
        CY_ZERO = 2'd1,
        CY_ONE  = 2'd2,
        CY_FLIP = 2'd3
    } cyctl_e;

    typedef enum logic [2:0] {
        SK_NEVER  = 3'd0,
        SK_ALWAYS = 3'd1,
        SK_CZERO  = 3'd2,
        SK_CSET   = 3'd3,
        SK_RZERO  = 3'd4,
        SK_RNZ    = 3'd5,
        SK_EITHER = 3'd6,
        SK_BOTH   = 3'd7
    } skip_e;

    // Packed MSB-first, so a cast of the instruction word yields the fields.
    typedef struct packed {
        logic                is_alc;
        logic [AC_IDX_W-1:0] src;
        logic [AC_IDX_W-1:0] dst;
        func_e               fn;
        shift_e              sh;
        cyctl_e              cy;
        logic                no_load;
        skip_e               sk;
    } alc_fields_t;

    typedef struct packed {
        logic  c;
        word_t r;
    } cr_t;

    function automatic alc_fields_t decode(input word_t w);
        return alc_fields_t'(w);
    endfunction

    function automatic logic precondition(input logic c, input cyctl_e cy);
        case (cy)
            CY_ZERO: return 1'b0;
            CY_ONE:  return 1'b1;
            CY_FLIP: return ~c;
            default: return c;
        endcase
    endfunction

endpackage

// File: rtl/alc_func_unit.sv
module alc_func_unit
    import alc_pkg::*;
(
    input  func_e fn,
    input  word_t src_val,
    input  word_t dst_val,
    input  logic  base_c,
    output cr_t   res
);
    logic [WORD_W-1:0] opa, opb;
    logic              cin;
    logic [WORD_W:0]   sum;

    always_comb begin
        opa = src_val;
        opb = '0;
        cin = 1'b0;
        case (fn)
            FN_COM: opa = ~src_val;
            FN_NEG: begin opa = ~src_val; cin = 1'b1; end
            FN_MOV: opa = src_val;
            FN_INC: cin = 1'b1;
            FN_ADC: begin opa = ~src_val; opb = dst_val; end
            FN_SUB: begin opa = ~src_val; opb = dst_val; cin = 1'b1; end
            FN_ADD: opb = dst_val;
            default: ;
        endcase
        sum = {1'b0, opa} + {1'b0, opb} + {{WORD_W{1'b0}}, cin};
        if (fn == FN_AND) begin
            res.r = src_val & dst_val;
            res.c = base_c;
        end else begin
            res.r = sum[WORD_W-1:0];
            res.c = base_c ^ sum[WORD_W];
        end
    end
endmodule

// File: rtl/alc_shifter.sv
module alc_shifter
    import alc_pkg::*;
(
    input  shift_e sh,
    input  cr_t    din,
    output cr_t    dout
);
    always_comb begin
        case (sh)
            SH_ROL:  dout = {din.r, din.c};
            SH_ROR:  dout = {din.r[0], din.c, din.r[WORD_W-1:1]};
            SH_SWAP: dout = {din.c, din.r[BYTE_W-1:0], din.r[WORD_W-1:BYTE_W]};
            default: dout = din;
        endcase
    end
endmodule

// File: rtl/alc_skip_eval.sv
module alc_skip_eval
    import alc_pkg::*;
(
    input  skip_e sel,
    input  cr_t   val,
    output logic  take
);
    logic rz;
    assign rz = (val.r == '0);

    always_comb begin
        case (sel)
            SK_ALWAYS: take = 1'b1;
            SK_CZERO:  take = ~val.c;
            SK_CSET:   take = val.c;
            SK_RZERO:  take = rz;
            SK_RNZ:    take = ~rz;
            SK_EITHER: take = ~val.c | rz;
            SK_BOTH:   take = val.c & ~rz;
            default:   take = 1'b0;
        endcase
    end
endmodule

// File: rtl/alc_exec_unit.sv
module alc_exec_unit
    import alc_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start_i,
    input  logic [WORD_W-1:0]        instr_i,
    output logic                     done_o,
    output logic                     skip_o,
    output logic                     carry_o,
    output logic [NUM_AC*WORD_W-1:0] acc_o
);
    alc_fields_t f;
    logic        accept;
    word_t       ac_q [NUM_AC];
    logic        carry_q, skip_q, done_q;
    logic        base_c, skip_now;
    cr_t         fn_res, sh_res;

    assign f      = decode(instr_i);
    assign accept = start_i & f.is_alc;
    assign base_c = precondition(carry_q, f.cy);

    alc_func_unit u_func (
        .fn      (f.fn),
        .src_val (ac_q[f.src]),
        .dst_val (ac_q[f.dst]),
        .base_c  (base_c),
        .res     (fn_res)
    );

    alc_shifter u_shift (
        .sh   (f.sh),
        .din  (fn_res),
        .dout (sh_res)
    );

    alc_skip_eval u_skip (
        .sel  (f.sk),
        .val  (sh_res),
        .take (skip_now)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q <= 1'b0;
            skip_q  <= 1'b0;
            done_q  <= 1'b0;
            for (int k = 0; k < NUM_AC; k++) ac_q[k] <= '0;
        end else begin
            done_q <= accept;
            if (accept) begin
                skip_q <= skip_now;
                if (!f.no_load) begin
                    carry_q <= sh_res.c;
                    for (int k = 0; k < NUM_AC; k++)
                        if (f.dst == AC_IDX_W'(k)) ac_q[k] <= sh_res.r;
                end
            end
        end
    end

    for (genvar g = 0; g < NUM_AC; g++) begin : g_acc_out
        assign acc_o[g*WORD_W +: WORD_W] = ac_q[g];
    end

    assign done_o  = done_q;
    assign skip_o  = skip_q;
    assign carry_o = carry_q;

    // R10
    done_after_start_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past(start_i && instr_i[15]));

    // R2
    foreign_word_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && !instr_i[15]) |=> ($stable(acc_o) && $stable(carry_o) && !done_o));

    // R7
    noload_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && instr_i[15] && instr_i[3]) |=> ($stable(acc_o) && $stable(carry_o)));

    // R8
    skip_always_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && instr_i[15] && instr_i[2:0] == 3'd1) |=> skip_o);

    // R8
    skip_never_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && instr_i[15] && instr_i[2:0] == 3'd0) |=> !skip_o);

    // R4
    and_forced_carry_chk: assert property (@(posedge clk) disable iff (rst)
        (start_i && instr_i[15] && instr_i[10:8] == 3'd7 && instr_i[7:6] == 2'd0
         && instr_i[5:4] == 2'd2 && !instr_i[3]) |=> carry_o);
endmodule

// File: tb/alc_exec_unit_tb_top.sv
module alc_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [15:0] instr_i = '0;
    logic        done_o, skip_o, carry_o;
    logic [63:0] acc_o;

    int checks = 0;
    int errors = 0;

    int m_ac [4];
    int m_c;

    always #2.5 clk = ~clk;

    alc_exec_unit dut_i (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .instr_i (instr_i),
        .done_o  (done_o),
        .skip_o  (skip_o),
        .carry_o (carry_o),
        .acc_o   (acc_o)
    );

    function automatic logic [15:0] mk(int s, int d, int fn, int sh, int cy, int nl, int sk);
        return {1'b1, 2'(s), 2'(d), 3'(fn), 2'(sh), 2'(cy), 1'(nl), 3'(sk)};
    endfunction

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic check_state(string tag);
        for (int k = 0; k < 4; k++)
            check(tag, $sformatf("ac%0d", k), int'(acc_o[k*16 +: 16]), m_ac[k]);
        check(tag, "carry", int'(carry_o), m_c);
    endtask

    // Execute one class instruction and compare against the arithmetic model.
    task automatic run(logic [15:0] w);
        int s, d, fn, sh, cy, nl, sk, c, r, t, co, exp_skip;
        string tag;
        s = w[14:13]; d = w[12:11]; fn = w[10:8]; sh = w[7:6];
        cy = w[5:4]; nl = w[3]; sk = w[2:0];
        c = m_c;
        case (cy)
            1: c = 0;
            2: c = 1;
            3: c = 1 - c;
            default: ;
        endcase
        co = 0;
        case (fn)
            0: r = 65535 - m_ac[s];
            1: begin t = 65536 - m_ac[s]; co = (m_ac[s] == 0) ? 1 : 0; r = t % 65536; end
            2: r = m_ac[s];
            3: begin t = m_ac[s] + 1; co = t / 65536; r = t % 65536; end
            4: begin t = (65535 - m_ac[s]) + m_ac[d]; co = t / 65536; r = t % 65536; end
            5: begin t = (65535 - m_ac[s]) + m_ac[d] + 1; co = t / 65536; r = t % 65536; end
            6: begin t = m_ac[s] + m_ac[d]; co = t / 65536; r = t % 65536; end
            default: r = m_ac[s] & m_ac[d];
        endcase
        c = c ^ co;
        case (sh)
            1: begin t = c * 65536 + r; c = r / 32768; r = (t * 2) % 65536 + t / 65536; end
            2: begin t = c * 65536 + r; c = r % 2; r = t / 2; end
            3: r = (r % 256) * 256 + r / 256;
            default: ;
        endcase
        case (sk)
            0: exp_skip = 0;
            1: exp_skip = 1;
            2: exp_skip = (c == 0);
            3: exp_skip = (c == 1);
            4: exp_skip = (r == 0);
            5: exp_skip = (r != 0);
            6: exp_skip = (c == 0 || r == 0);
            default: exp_skip = (c == 1 && r != 0);
        endcase
        if (nl == 0) begin
            m_ac[d] = r;
            m_c = c;
        end
        @(negedge clk);
        instr_i = w;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (nl != 0)        tag = "R7";
        else if (s == d)    tag = "R9";
        else if (sh != 0)   tag = "R6";
        else if (cy != 0)   tag = "R4";
        else                tag = "R5";
        check_state(tag);
        check("R8", "skip", int'(skip_o), exp_skip);
        check("R10", "done", int'(done_o), 1);
    endtask

    // Plant a value MSB first using copy-with-left-rotate and forced carry.
    task automatic plant(int idx, int v);
        for (int b = 15; b >= 0; b--)
            run(mk(idx, idx, 2, 1, ((v >> b) & 1) ? 2 : 1, 0, 0));
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R10 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 4; k++) m_ac[k] = 0;
        m_c = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_state("R1");
        check("R1", "skip", int'(skip_o), 0);
        check("R1", "done", int'(done_o), 0);

        // R3 literal encoding: AC3 <= AC2 + AC3, no shift, carry kept, no skip
        plant(2, 16'h1234);
        plant(3, 16'h1111);
        @(negedge clk);
        instr_i = 16'hDE00;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R3", "ac3", int'(acc_o[48 +: 16]), 16'h2345);
        check("R3", "ac2", int'(acc_o[32 +: 16]), 16'h1234);
        m_ac[3] = 16'h2345;
        @(negedge clk);
        check("R10", "done drop", int'(done_o), 0);
        check_state("R10");

        // R2 non-class word is ignored
        @(negedge clk);
        instr_i = 16'h5E0B;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check_state("R2");
        check("R2", "done", int'(done_o), 0);

        // Sweep every field combination over rotating operands
        for (int i = 0; i < 2048; i++) begin
            int s, d;
            if (i % 16 == 0) begin
                for (int k = 0; k < 4; k++) begin
                    int v;
                    case ((i / 16 + k) % 8)
                        0: v = 0;
                        1: v = 16'hFFFF;
                        2: v = 16'h8000;
                        3: v = 16'h00FF;
                        default: v = (i * 40503 + k * 12345 + 7) % 65536;
                    endcase
                    plant(k, v);
                end
            end
            s = ((i >> 2) ^ (i >> 5)) & 3;
            d = ((i >> 1) ^ (i >> 6) ^ (i >> 9)) & 3;
            run(mk(s, d, i & 7, (i >> 3) & 3, (i >> 5) & 3, (i >> 7) & 1, (i >> 8) & 7));
        end
        finish_run();
    end
endmodule